// File: doc/BRIEF.md
# Serpentine Oscillator Fill Controller

This block decides which cells of a tri-state inverter array are switched on. The fraction of cells that are on, the fill, sets the frequency of a ring oscillator. The fill is held as two thermometer codes. A row code marks the rows that are completely on. A column code sets how far the one partially filled row has advanced. On every clock the loop filter can raise the fill by one cell (`step_up`), lower it by one cell (`step_dn`), or leave it unchanged. The block turns the two codes into one enable bit per cell. It also reports the fill as a binary count, and that count forms the upper part of the frequency word.

Rows are filled in serpentine order:
- Even rows fill from column 0 upward. A cell in an even row follows its column bit directly.
- Odd rows fill from the highest column downward. A cell in an odd row uses the inverse of its column bit.
- When a row is completed, the column code is not reset. Because the next row has the opposite parity, it starts from the edge the previous row ended on.
- As a result, every step changes exactly one cell and the fill stays monotonic.

A per-row force input can switch whole rows on without disturbing the pointers. A dither count input supplies the low bits of the frequency word.

The sequencer has three states:
- `ST_EVEN`: the partial row is even.
- `ST_ODD`: the partial row is odd.
- `ST_FULL`: every row is on.

The transitions between them are:
- Row-complete on increment: `ST_EVEN`→`ST_ODD` or `ST_ODD`→`ST_EVEN`. If the completed row was the last row, the move goes to `ST_FULL` instead.
- Row-reopen on decrement at an empty partial row: `ST_EVEN`→`ST_ODD` or `ST_ODD`→`ST_EVEN`.
- Unfill from full: `ST_FULL`→`ST_EVEN` or `ST_ODD`, according to the parity of the last row.
- Every other step stays in the current state and only moves the column code.

Top module: `serp_fill_ctrl`

## Requirements
- R1: After reset, `fill_cnt` is 0, every `cell_en`, `col_sel` and `row_full` bit is 0.
- R2: A cycle with `step_up`=1 and `step_dn`=0 below full raises `fill_cnt` by exactly one, visible after that clock edge.
- R3: A cycle with `step_dn`=1 and `step_up`=0 above empty lowers `fill_cnt` by exactly one.
- R4: A cycle with both step inputs equal (both 0 or both 1) leaves `fill_cnt` and `cell_en` unchanged.
- R5: With fill F = r*COLS + c (0 ≤ c < COLS):
  - Rows below r are fully on and rows above r are off.
  - If row r is even, its columns 0..c-1 are on.
  - If row r is odd, its columns COLS-c..COLS-1 are on.
  - Cell (row j, column i) is `cell_en` bit j*COLS+i.
- R6: `row_full` bit j is 1 exactly when row j is complete. `col_sel` is the thermometer code (ones from bit 0) of length c on an even partial row and of length COLS-c on an odd one. At full fill, `col_sel` is all ones if the last row is even and all zeros if it is odd.
- R7: At full fill (ROWS*COLS) a raising step is ignored and the fill stays full.
- R8: At zero fill a lowering step is ignored and the fill stays zero.
- R9: `row_force` bit j turns on every cell of row j combinationally. It leaves `fill_cnt`, `col_sel` and `row_full` unchanged, and when it is released the cells follow R5 again.
- R10: `freq_word` is `fill_cnt` in its upper bits with `dith_cnt` in its low DW bits.
- R11: With no row forced, the number of enabled cells equals `fill_cnt`, and from one cycle to the next at most one cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_up | input | 1 | Raise the fill by one cell this cycle |
| step_dn | input | 1 | Lower the fill by one cell this cycle |
| row_force | input | ROWS | Force whole rows on |
| dith_cnt | input | DW | Dither count, low bits of the frequency word |
| row_full | output | ROWS | Row thermometer code, bit j = row j complete |
| col_sel | output | COLS | Column thermometer code |
| cell_en | output | ROWS*COLS | Per-cell enable, bit j*COLS+i |
| fill_cnt | output | FW | Number of cells switched on by the pointers |
| freq_word | output | FW+DW | {fill_cnt, dith_cnt} |

## Verification
The bench builds the block with ROWS=4, COLS=3 and DW=2, which gives twelve cells. With so few cells, one run climbs from empty to full and back again. That run crosses every row seam in both directions, leaves each parity of partial row through both edges, and reaches `ST_FULL` from an odd last row, so the unfill-from-full path that reopens an odd row is taken. The odd column count also means an odd row's inverted column code never mirrors the even one by symmetry. The expected enables, column code and row code are all recomputed from the fill count alone.

// File: rtl/fill_pkg.sv
package fill_pkg;

    // Position of the partial row, or the saturated top
    typedef enum logic [1:0] {
        ST_EVEN = 2'd0,
        ST_ODD  = 2'd1,
        ST_FULL = 2'd2
    } fill_state_t;

    // Thermometer register operations
    typedef enum logic [1:0] {
        SH_HOLD = 2'd0,
        SH_IN   = 2'd1,   // one more ones bit at the low end
        SH_OUT  = 2'd2    // drop the highest ones bit
    } shift_op_t;

endpackage

// File: rtl/fill_therm_reg.sv
module fill_therm_reg
    import fill_pkg::*;
#(
    parameter int W = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  shift_op_t op,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                SH_IN:   q <= {q[W-2:0], 1'b1};
                SH_OUT:  q <= {1'b0, q[W-1:1]};
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/fill_seq.sv
module fill_seq
    import fill_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_up,
    input  logic            step_dn,
    input  logic [COLS-1:0] col_q,
    input  logic [ROWS-1:0] row_q,
    output fill_state_t     state,
    output shift_op_t       col_op,
    output shift_op_t       row_op
);

    localparam bit LAST_ODD = ((ROWS - 1) % 2) == 1;

    fill_state_t state_q;
    fill_state_t state_d;
    logic        inc;
    logic        dec;
    logic        last_row;
    logic        bottom_row;

    assign inc        = step_up & ~step_dn;
    assign dec        = step_dn & ~step_up;
    assign last_row   = row_q[ROWS-2];
    assign bottom_row = ~row_q[0];
    assign state      = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        col_op  = SH_HOLD;
        row_op  = SH_HOLD;
        unique case (state_q)
            ST_EVEN: begin
                if (inc) begin
                    col_op = SH_IN;
                    if (col_q[COLS-2]) begin
                        row_op  = SH_IN;
                        state_d = last_row ? ST_FULL : ST_ODD;
                    end
                end else if (dec) begin
                    if (col_q[0]) begin
                        col_op = SH_OUT;
                    end else if (!bottom_row) begin
                        col_op  = SH_IN;
                        row_op  = SH_OUT;
                        state_d = ST_ODD;
                    end
                end
            end
            ST_ODD: begin
                if (inc) begin
                    col_op = SH_OUT;
                    if (col_q[0] && !col_q[1]) begin
                        row_op  = SH_IN;
                        state_d = last_row ? ST_FULL : ST_EVEN;
                    end
                end else if (dec) begin
                    if (col_q[COLS-1]) begin
                        col_op  = SH_OUT;
                        row_op  = SH_OUT;
                        state_d = ST_EVEN;
                    end else begin
                        col_op = SH_IN;
                    end
                end
            end
            ST_FULL: begin
                if (dec) begin
                    row_op  = SH_OUT;
                    col_op  = LAST_ODD ? SH_IN : SH_OUT;
                    state_d = LAST_ODD ? ST_ODD : ST_EVEN;
                end
            end
            default: begin
                state_d = ST_EVEN;
            end
        endcase
    end

endmodule

// File: rtl/fill_cells.sv
module fill_cells #(
    parameter int ROWS = 16,
    parameter int COLS = 17
) (
    input  logic [ROWS-1:0]      row_q,
    input  logic [COLS-1:0]      col_q,
    input  logic [ROWS-1:0]      row_force,
    output logic [ROWS*COLS-1:0] cell_en
);

    for (genvar j = 0; j < ROWS; j++) begin : g_row
        logic reached;
        if (j == 0) begin : g_first
            assign reached = 1'b1;
        end else begin : g_rest
            assign reached = row_q[j-1];
        end
        for (genvar i = 0; i < COLS; i++) begin : g_col
            logic col_bit;
            if ((j % 2) == 0) begin : g_even
                assign col_bit = col_q[i];
            end else begin : g_odd
                assign col_bit = ~col_q[i];
            end
            assign cell_en[j*COLS+i] = row_force[j] | row_q[j] | (reached & col_bit);
        end
    end

endmodule

// File: rtl/serp_fill_ctrl.sv
module serp_fill_ctrl
    import fill_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 17,
    parameter int DW   = 3,
    parameter int FW   = $clog2(ROWS*COLS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_up,
    input  logic                 step_dn,
    input  logic [ROWS-1:0]      row_force,
    input  logic [DW-1:0]        dith_cnt,
    output logic [ROWS-1:0]      row_full,
    output logic [COLS-1:0]      col_sel,
    output logic [ROWS*COLS-1:0] cell_en,
    output logic [FW-1:0]        fill_cnt,
    output logic [FW+DW-1:0]     freq_word
);

    fill_state_t     state;
    shift_op_t       col_op;
    shift_op_t       row_op;
    logic [COLS-1:0] col_q;
    logic [ROWS-1:0] row_q;
    int              rows_on;
    int              cols_on;
    int              part;

    fill_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (step_up),
        .step_dn (step_dn),
        .col_q   (col_q),
        .row_q   (row_q),
        .state   (state),
        .col_op  (col_op),
        .row_op  (row_op)
    );

    fill_therm_reg #(.W(COLS)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (col_op),
        .q     (col_q)
    );

    fill_therm_reg #(.W(ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (row_op),
        .q     (row_q)
    );

    fill_cells #(.ROWS(ROWS), .COLS(COLS)) u_cells (
        .row_q     (row_q),
        .col_q     (col_q),
        .row_force (row_force),
        .cell_en   (cell_en)
    );

    // Binary fill from the two thermometer codes
    always_comb begin
        rows_on = 0;
        cols_on = 0;
        for (int j = 0; j < ROWS; j++) begin
            rows_on = rows_on + int'(row_q[j]);
        end
        for (int i = 0; i < COLS; i++) begin
            cols_on = cols_on + int'(col_q[i]);
        end
        unique case (state)
            ST_EVEN: part = cols_on;
            ST_ODD:  part = COLS - cols_on;
            default: part = 0;
        endcase
    end

    assign fill_cnt  = FW'(rows_on * COLS + part);
    assign freq_word = {fill_cnt, dith_cnt};
    assign row_full  = row_q;
    assign col_sel   = col_q;

endmodule

// File: rtl/serp_fill_chk.sv
module serp_fill_chk #(
    parameter int ROWS = 16,
    parameter int COLS = 17,
    parameter int FW   = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 step_up,
    input logic                 step_dn,
    input logic [ROWS-1:0]      row_force,
    input logic [ROWS*COLS-1:0] cell_en,
    input logic [FW-1:0]        fill_cnt
);

    localparam int MAXF = ROWS * COLS;

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn && int'(fill_cnt) < MAXF)
        |=> int'(fill_cnt) == int'($past(fill_cnt)) + 1);

    // R3
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !step_up && fill_cnt != '0)
        |=> int'(fill_cnt) + 1 == int'($past(fill_cnt)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up == step_dn) && (row_force == '0)
        |=> $stable(fill_cnt) && (($past(cell_en) == cell_en) || (row_force != '0)));

    // R7
    full_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_cnt) == MAXF) && step_up && !step_dn
        |=> int'(fill_cnt) == MAXF);

    // R8
    empty_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) && step_dn && !step_up
        |=> fill_cnt == '0);

    // R11
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_force == '0) |-> $countones(cell_en) == int'(fill_cnt));

    // R11
    one_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_force == '0) ##1 (row_force == '0)
        |-> $countones(cell_en ^ $past(cell_en)) <= 1);

endmodule

bind serp_fill_ctrl serp_fill_chk #(.ROWS(ROWS), .COLS(COLS), .FW(FW)) u_fill_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .row_force (row_force),
    .cell_en   (cell_en),
    .fill_cnt  (fill_cnt)
);

// File: tb/serp_fill_ctrl_bench.sv
`timescale 1ns/1ps
module serp_fill_ctrl_bench;

    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int DW   = 2;
    localparam int FW   = $clog2(ROWS*COLS + 1);
    localparam int NC   = ROWS * COLS;
    localparam int MAXF = NC;

    typedef struct {
        int                 fill;
        logic [NC-1:0]      cells;
        logic [COLS-1:0]    col;
        logic [ROWS-1:0]    rf;
        logic [FW+DW-1:0]   fw;
        string              tag;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 step_up = 1'b0;
    logic                 step_dn = 1'b0;
    logic [ROWS-1:0]      row_force = '0;
    logic [DW-1:0]        dith_cnt = '0;
    logic [ROWS-1:0]      row_full;
    logic [COLS-1:0]      col_sel;
    logic [NC-1:0]        cell_en;
    logic [FW-1:0]        fill_cnt;
    logic [FW+DW-1:0]     freq_word;

    int    total = 0;
    int    bad = 0;
    int    f = 0;
    item_t sb[$];

    always #4 clk = ~clk;

    serp_fill_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_serp_fill_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .row_force (row_force),
        .dith_cnt  (dith_cnt),
        .row_full  (row_full),
        .col_sel   (col_sel),
        .cell_en   (cell_en),
        .fill_cnt  (fill_cnt),
        .freq_word (freq_word)
    );

    function automatic logic [31:0] therm(int n);
        if (n <= 0) return 32'h0;
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << n) - 32'h1;
    endfunction

    function automatic logic [NC-1:0] exp_cells(int fv, logic [ROWS-1:0] frc);
        logic [NC-1:0] v = '0;
        int r = fv / COLS;
        int c = fv % COLS;
        for (int j = 0; j < ROWS; j++) begin
            for (int i = 0; i < COLS; i++) begin
                logic on;
                on = frc[j] || (j < r) ||
                     ((j == r) && (((j % 2) == 0) ? (i < c) : (i >= COLS - c)));
                v[j*COLS+i] = on;
            end
        end
        return v;
    endfunction

    function automatic logic [COLS-1:0] exp_col(int fv);
        int r = fv / COLS;
        int c = fv % COLS;
        if (fv == MAXF) return (((ROWS - 1) % 2) == 0) ? COLS'(therm(COLS)) : '0;
        return ((r % 2) == 0) ? COLS'(therm(c)) : COLS'(therm(COLS - c));
    endfunction

    task automatic chk(bit ok, string msg, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected outcome
    task automatic step(bit up, bit dn, logic [ROWS-1:0] frc, logic [DW-1:0] d, string tag);
        item_t e;
        step_up   = up;
        step_dn   = dn;
        row_force = frc;
        dith_cnt  = d;
        @(posedge clk);
        #1;
        if (up && !dn && f < MAXF) f++;
        else if (dn && !up && f > 0) f--;
        e.fill  = f;
        e.cells = exp_cells(f, frc);
        e.col   = exp_col(f);
        e.rf    = ROWS'(therm(f / COLS));
        e.fw    = {FW'(f), d};
        e.tag   = tag;
        sb.push_back(e);
        step_up = 1'b0;
        step_dn = 1'b0;
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        item_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(int'(fill_cnt) == e.fill, {e.tag, " fill_cnt"}, 64'(fill_cnt), 64'(e.fill));
            chk(cell_en == e.cells, {e.tag, " R5 R11 cell_en"}, 64'(cell_en), 64'(e.cells));
            chk(col_sel == e.col, {e.tag, " R6 col_sel"}, 64'(col_sel), 64'(e.col));
            chk(row_full == e.rf, {e.tag, " R6 row_full"}, 64'(row_full), 64'(e.rf));
            chk(freq_word == e.fw, {e.tag, " R10 freq_word"}, 64'(freq_word), 64'(e.fw));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired, all requirements act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(fill_cnt == '0, "R1 fill_cnt", 64'(fill_cnt), 64'd0);
        chk(cell_en == '0, "R1 cell_en", 64'(cell_en), 64'd0);
        chk(col_sel == '0, "R1 col_sel", 64'(col_sel), 64'd0);
        chk(row_full == '0, "R1 row_full", 64'(row_full), 64'd0);

        step(1'b0, 1'b0, '0, 2'd0, "R4 idle");
        step(1'b1, 1'b1, '0, 2'd1, "R4 both");
        step(1'b0, 1'b1, '0, 2'd2, "R8 empty");
        for (int k = 0; k < MAXF; k++) begin
            step(1'b1, 1'b0, '0, DW'(k), "R2 up");
        end
        step(1'b1, 1'b0, '0, 2'd3, "R7 full");
        step(1'b1, 1'b0, '0, 2'd0, "R7 full");
        step(1'b1, 1'b1, '0, 2'd1, "R4 both at full");
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b1, '0, DW'(k), "R3 down");
        end
        step(1'b0, 1'b0, 4'b1010, 2'd2, "R9 force hold");
        step(1'b1, 1'b0, 4'b1010, 2'd3, "R9 force step");
        step(1'b0, 1'b1, 4'b0001, 2'd1, "R9 force low row");
        step(1'b0, 1'b0, '0, 2'd0, "R9 released");
        while (f > 0) begin
            step(1'b0, 1'b1, '0, 2'd2, "R3 down");
        end
        step(1'b0, 1'b1, '0, 2'd3, "R8 empty");
        step(1'b1, 1'b0, '0, 2'd0, "R2 up from empty");
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule